// File: doc/BRIEF.md
# Planar Memory Read Datapath

This block serves host reads from a video memory organised as four parallel byte-wide planes. For each accepted read request it receives the four bytes stored at one address. It then returns a single byte to the host. In raw mode that byte is one plane's data. The plane is picked either by a two-bit plane-select field or, when chain-4 addressing is on, by the two low address bits. In colour-compare mode the byte is a per-pixel match mask instead. A mask bit is 1 when every plane that is enabled for comparison holds, at that bit position, the colour bit assigned to that plane.

Every accepted read also captures all four plane bytes in a bank of holding latches. The latches keep their value until the next accepted read. Their contents leave the block on a dedicated output so that a neighbouring write datapath can copy them back to memory.

Requests arrive on a valid/ready interface. The response leaves on a second valid/ready interface through a single output register. The request side is ready whenever that register is empty or is being drained in the same cycle. A response that is not taken stays on the outputs unchanged. The mode, plane-select and compare inputs are plain levels, and they are sampled when a request is accepted.

Top module: `vplane_rd_path`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_data` is 0x00 and `latch_q` is all zeros.
- R2: `req_ready` equals `!rsp_valid || rsp_ready`. A request accepted at a clock edge (`req_valid && req_ready`) makes `rsp_valid` 1 after that same edge. If no request is accepted, `rsp_valid` goes to 0 once the response is taken (`rsp_valid && rsp_ready`).
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` stays 1 and `rsp_data` does not change.
- R4: With `mode_reg[3]`=0 and `chain4_en`=0, `rsp_data` is plane `map_sel`. Plane p is `plane_data[8p+7:8p]`.
- R5: With `mode_reg[3]`=0 and `chain4_en`=1, `rsp_data` is plane `addr_lo`, and `map_sel` has no effect.
- R6: With `mode_reg[3]`=1, bit i of `rsp_data` is 1 exactly when bit i of plane p equals `cmp_colour[p]` for every plane p whose `cmp_care[p]` is 1. The `chain4_en`, `map_sel` and `addr_lo` inputs have no effect in this mode.
- R7: With `mode_reg[3]`=1 and `cmp_care` = 0000, `rsp_data` is 0xFF.
- R8: After an edge that accepts a request, `latch_q` equals the `plane_data` presented with that request, in both read modes.
- R9: After an edge that accepts no request, `latch_q` is unchanged. This includes cycles in which `req_valid` is 1 but `req_ready` is 0.
- R10: Bits 7:4 and 2:0 of `mode_reg` (the write-mode field and the others) have no effect on `rsp_data` or `latch_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| addr_lo | input | 2 | Two low bits of the memory address |
| plane_data | input | 32 | Four plane bytes, plane p in bits 8p+7:8p |
| mode_reg | input | 8 | Graphics mode register; bit 3 selects compare mode |
| chain4_en | input | 1 | Chain-4 addressing: plane chosen by address |
| map_sel | input | 2 | Plane-select field for raw reads |
| cmp_colour | input | 4 | Colour-compare value, bit p for plane p |
| cmp_care | input | 4 | Compare enables, bit p includes plane p |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Host takes the response this cycle |
| rsp_data | output | 8 | Returned byte |
| latch_q | output | 32 | Holding latches, plane p in bits 8p+7:8p |

## Verification
The reference model goes after the plane-choice corner cases. In one case chain-4 is on while `map_sel` points elsewhere, so a design that ignored chain-4 would return the wrong plane. In another, compare mode runs with chain-4 and `addr_lo` varying, so a design that let those inputs leak into the mask would be caught.

Compare mode is driven with single, mixed and empty care sets. An empty set must yield 0xFF, and a design that treated cleared care bits as mismatches would return 0x00 instead.

Long stalls on `rsp_ready` are applied while `req_valid` stays high. They expose a design that overwrites the held response or reloads the latches without accepting the request. Random values in the unused `mode_reg` bits expose a design that decoded the wrong bit as the read mode.

// File: rtl/vprd_pkg.sv
package vprd_pkg;
  localparam int RD_MODE_BIT = 3;
  typedef enum logic {
    RD_RAW = 1'b0,
    RD_CMP = 1'b1
  } rd_kind_e;
endpackage

// File: rtl/vprd_plane_pick.sv
module vprd_plane_pick #(
  parameter int NPL  = 4,
  parameter int BW   = 8,
  localparam int SELW = $clog2(NPL)
) (
  input  logic [NPL*BW-1:0] planes,
  input  logic              chain4,
  input  logic [SELW-1:0]   map_sel,
  input  logic [SELW-1:0]   addr_lo,
  output logic [BW-1:0]     byte_out
);
  logic [SELW-1:0] sel;

  assign sel = chain4 ? addr_lo : map_sel;

  always_comb begin
    byte_out = '0;
    for (int p = 0; p < NPL; p++) begin
      if (SELW'(p) == sel) byte_out = planes[p*BW +: BW];
    end
  end
endmodule

// File: rtl/vprd_colour_match.sv
module vprd_colour_match #(
  parameter int NPL = 4,
  parameter int BW  = 8
) (
  input  logic [NPL*BW-1:0] planes,
  input  logic [NPL-1:0]    colour,
  input  logic [NPL-1:0]    care,
  output logic [BW-1:0]     mask
);
  for (genvar i = 0; i < BW; i++) begin : g_bit
    logic [NPL-1:0] miss;
    for (genvar p = 0; p < NPL; p++) begin : g_pl
      assign miss[p] = care[p] & (planes[p*BW + i] ^ colour[p]);
    end
    assign mask[i] = ~|miss;
  end
endmodule

// File: rtl/vprd_latch_bank.sv
module vprd_latch_bank #(
  parameter int NPL = 4,
  parameter int BW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NPL*BW-1:0] din,
  output logic [NPL*BW-1:0] q
);
  for (genvar p = 0; p < NPL; p++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q[p*BW +: BW] <= '0;
      else if (load) q[p*BW +: BW] <= din[p*BW +: BW];
    end
  end

  // R8
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(din));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/vplane_rd_path.sv
module vplane_rd_path #(
  parameter int NPL   = 4,
  parameter int BW    = 8,
  parameter int MODEW = 8,
  localparam int SELW = $clog2(NPL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SELW-1:0]   addr_lo,
  input  logic [NPL*BW-1:0] plane_data,
  input  logic [MODEW-1:0]  mode_reg,
  input  logic              chain4_en,
  input  logic [SELW-1:0]   map_sel,
  input  logic [NPL-1:0]    cmp_colour,
  input  logic [NPL-1:0]    cmp_care,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BW-1:0]     rsp_data,
  output logic [NPL*BW-1:0] latch_q
);
  import vprd_pkg::*;

  logic           accept;
  logic [BW-1:0]  raw_byte;
  logic [BW-1:0]  cmp_byte;
  logic [BW-1:0]  next_byte;
  rd_kind_e       kind;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign kind      = rd_kind_e'(mode_reg[RD_MODE_BIT]);

  vprd_plane_pick #(.NPL(NPL), .BW(BW)) u_pick (
    .planes(plane_data), .chain4(chain4_en), .map_sel(map_sel),
    .addr_lo(addr_lo), .byte_out(raw_byte)
  );

  vprd_colour_match #(.NPL(NPL), .BW(BW)) u_cmp (
    .planes(plane_data), .colour(cmp_colour), .care(cmp_care), .mask(cmp_byte)
  );

  vprd_latch_bank #(.NPL(NPL), .BW(BW)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(accept), .din(plane_data), .q(latch_q)
  );

  assign next_byte = (kind == RD_CMP) ? cmp_byte : raw_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= next_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R2
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  // R7
  empty_care_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mode_reg[RD_MODE_BIT] && cmp_care == '0)
      |=> rsp_data == '1);
  // R5
  chain4_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mode_reg[RD_MODE_BIT] && chain4_en)
      |=> rsp_data == $past(plane_data[addr_lo*BW +: BW]));
endmodule

// File: tb/sim_vplane_rd_path.sv
module sim_vplane_rd_path;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 0, chain4_en = 0;
  logic [1:0] addr_lo = 0, map_sel = 0;
  logic [31:0] plane_data = 0;
  logic [7:0] mode_reg = 0;
  logic [3:0] cmp_colour = 0, cmp_care = 0;
  wire req_ready, rsp_valid;
  wire [7:0] rsp_data;
  wire [31:0] latch_q;

  int n_chk = 0, n_fail = 0;

  vplane_rd_path u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .addr_lo(addr_lo), .plane_data(plane_data), .mode_reg(mode_reg),
    .chain4_en(chain4_en), .map_sel(map_sel), .cmp_colour(cmp_colour),
    .cmp_care(cmp_care), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .latch_q(latch_q)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [31:0] pd, input logic [7:0] md,
      input logic c4, input logic [1:0] ms, input logic [1:0] al,
      input logic [3:0] col, input logic [3:0] care);
    logic [7:0] r;
    if (md[3]) begin
      r = 8'hFF;
      for (int i = 0; i < 8; i++)
        for (int p = 0; p < 4; p++)
          if (care[p] && (pd[p*8+i] != col[p])) r[i] = 1'b0;
    end else begin
      int pl;
      pl = c4 ? int'(al) : int'(ms);
      r = pd[pl*8 +: 8];
    end
    return r;
  endfunction

  logic m_valid = 0;
  logic [7:0] m_data = 0;
  logic [31:0] m_latch = 0;
  string data_tag = "R1", latch_tag = "R1";

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P*100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(rsp_data == 0, "R1 rsp_data", 32'(rsp_data), 0);
    chk(latch_q == 0, "R1 latch_q", latch_q, 0);
    rst_n = 1;
    for (int ph = 0; ph < 7; ph++) begin
      for (int cyc = 0; cyc < 400; cyc++) begin
        @(negedge clk);
        chk(rsp_valid == m_valid, "R2 rsp_valid", 32'(rsp_valid), 32'(m_valid));
        if (m_valid) chk(rsp_data == m_data, data_tag, 32'(rsp_data), 32'(m_data));
        chk(latch_q == m_latch, latch_tag, latch_q, m_latch);
        // stimulus
        plane_data = $urandom;
        addr_lo = 2'($urandom); map_sel = 2'($urandom);
        cmp_colour = 4'($urandom); cmp_care = 4'($urandom);
        mode_reg = 8'($urandom);
        req_valid = ($urandom % 4) != 0;
        rsp_ready = ($urandom % 3) != 0;
        case (ph)
          0: begin mode_reg[3] = 0; chain4_en = 0; end
          1: begin mode_reg[3] = 0; chain4_en = 1; end
          2: begin mode_reg[3] = 1; chain4_en = 1'($urandom); end
          3: begin mode_reg[3] = 1; cmp_care = 4'b0000; chain4_en = 1'($urandom); end
          4: begin mode_reg[3] = 1; cmp_care = 4'b0001 << ($urandom % 4); end
          5: begin req_valid = 1; rsp_ready = ($urandom % 6) == 0; chain4_en = 1'($urandom); end
          default: chain4_en = 1'($urandom);
        endcase
        #1;
        chk(req_ready == (!m_valid || rsp_ready), "R2 req_ready",
            32'(req_ready), 32'(!m_valid || rsp_ready));
        if (req_valid && (!m_valid || rsp_ready)) begin
          m_valid = 1;
          m_data = ref_byte(plane_data, mode_reg, chain4_en, map_sel, addr_lo,
                            cmp_colour, cmp_care);
          m_latch = plane_data;
          latch_tag = "R8 latch load";
          if (mode_reg[3]) data_tag = (cmp_care == 0) ? "R7 empty care" : "R6 compare";
          else data_tag = chain4_en ? "R5 chain4 pick R10" : "R4 map_sel pick R10";
        end else begin
          latch_tag = "R9 latch hold";
          if (m_valid && !rsp_ready) data_tag = "R3 held response";
          else if (m_valid) m_valid = 0;
        end
      end
    end
    @(negedge clk);
    chk(rsp_valid == m_valid, "R2 rsp_valid", 32'(rsp_valid), 32'(m_valid));
    chk(latch_q == m_latch, latch_tag, latch_q, m_latch);
    finish_run();
  end
endmodule